// File: doc/BRIEF.md
# Overflow-Trapping Integer Arithmetic Unit

This block is a two-stage integer execute unit that performs signed add, subtract and multiply on 64-bit operands and raises an integer-overflow trap when the signed result does not fit. Each operation comes in two widths. The longword forms work on the low 32 bits of each operand and deliver a sign-extended 32-bit result. The quadword forms work on the full 64 bits.

An operation is issued with `issue_vld`, a group select and a 7-bit function code. Exactly two clock edges later the unit retires it. At retirement it asserts `wr_en` with the destination value on `wr_data` and, in the same cycle, pulses `ovf_trap` if the operation overflowed. The destination value is always delivered, including when the trap fires, so a trap handler sees the wrapped result already committed. Every operation has the same latency, so one operation can be issued every cycle and results leave in issue order.

Top module: `trap_int_unit`

## Requirements
- R1: A synchronous active-high `rst` drives `wr_en` and `ovf_trap` low at the next edge and discards any operation in flight.
- R2: An operation sampled with `issue_vld` high on edge k and a recognised code produces a one-cycle `wr_en` pulse after edge k+1, and at no other time.
- R3: `ovf_trap` is only ever high in a cycle where `wr_en` is high.
- R4: With `grp_mul`=0, code 0x40 is longword add and 0x49 is longword subtract. Both operands are sign-extended from bit 31. `wr_data` is bit 31 of the 64-bit result replicated over bits 63:32, with the result's low 32 bits below. The trap fires when the 64-bit result differs from that value.
- R5: With `grp_mul`=0, code 0x60 is quadword add (`wr_data` = a+b mod 2^64). The trap fires when both operands have the same sign and the sum's bit 63 differs from it.
- R6: With `grp_mul`=0, code 0x69 is quadword subtract (`wr_data` = a-b mod 2^64). The trap fires when the operands' signs differ and the difference's bit 63 differs from a's.
- R7: With `grp_mul`=1, code 0x40 is longword multiply. Operands are sign-extended from bit 31 and the result is sign-extended from bit 31. The trap fires when the signed product lies outside [-2^31, 2^31-1].
- R8: With `grp_mul`=1, code 0x60 is quadword multiply. `wr_data` is the low 64 bits of the signed 128-bit product. The trap fires when the product lies outside [-2^63, 2^63-1]. For example, (-2^63) x (-1) gives -2^63 and traps.
- R9: When the trap fires, `wr_en` is high in the same cycle and `wr_data` holds the wrapped result.
- R10: An unrecognised code (for example 0x41 or 0x49 with `grp_mul`=1), or `issue_vld` low, produces no `wr_en` and no `ovf_trap`.
- R11: Operations issued on consecutive cycles retire on consecutive cycles in issue order, each with its own result and trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | Operation valid this cycle |
| grp_mul | input | 1 | 0 selects the add/subtract group, 1 selects the multiply group |
| func | input | 7 | Function code within the group |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| wr_en | output | 1 | Destination write strobe |
| wr_data | output | 64 | Destination value |
| ovf_trap | output | 1 | Integer overflow exception pulse |

## Verification
The result write and the overflow exception share a cycle whenever an operation overflows. The bench provokes this with operands at the signed limits of each width: the largest positive value plus one, the most negative value minus one, the most negative value times minus one, and longword products that spill past 32 bits. In each case it checks that `wr_en` and `ovf_trap` rise together and that `wr_data` carries the wrapped value that a reference model computes by wide signed arithmetic. It also checks that non-overflowing neighbours of those operands retire with the trap low.

// File: rtl/tiu_pkg.sv
package tiu_pkg;
    localparam int XLEN = 64;
    localparam int HLEN = 32;
    localparam int FN_W = 7;

    localparam logic [FN_W-1:0] FN_LONG_ADD = 7'h40;
    localparam logic [FN_W-1:0] FN_LONG_SUB = 7'h49;
    localparam logic [FN_W-1:0] FN_QUAD_ADD = 7'h60;
    localparam logic [FN_W-1:0] FN_QUAD_SUB = 7'h69;
    localparam logic [FN_W-1:0] FN_LONG_MUL = 7'h40;
    localparam logic [FN_W-1:0] FN_QUAD_MUL = 7'h60;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADDL,
        OP_SUBL,
        OP_ADDQ,
        OP_SUBQ,
        OP_MULL,
        OP_MULQ
    } op_e;

    typedef struct packed {
        logic            vld;
        op_e             op;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } issue_t;

    typedef struct packed {
        logic            wen;
        logic            trap;
        logic [XLEN-1:0] data;
    } retire_t;

    typedef struct packed {
        issue_t  s1;
        retire_t s2;
    } pipe_t;
endpackage

// File: rtl/tiu_decode.sv
module tiu_decode
    import tiu_pkg::*;
(
    input  logic            vld,
    input  logic            grp_mul,
    input  logic [FN_W-1:0] func,
    output op_e             op
);
    always_comb begin
        op = OP_NONE;
        if (vld) begin
            if (grp_mul) begin
                case (func)
                    FN_LONG_MUL: op = OP_MULL;
                    FN_QUAD_MUL: op = OP_MULQ;
                    default:     op = OP_NONE;
                endcase
            end else begin
                case (func)
                    FN_LONG_ADD: op = OP_ADDL;
                    FN_LONG_SUB: op = OP_SUBL;
                    FN_QUAD_ADD: op = OP_ADDQ;
                    FN_QUAD_SUB: op = OP_SUBQ;
                    default:     op = OP_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/tiu_addsub.sv
module tiu_addsub #(
    parameter int W  = 64,
    parameter int HW = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         narrow,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam int EXT = W - HW;

    logic [W-1:0] full;
    logic [W-1:0] narrow_res;
    logic [W-1:0] sign_diff;
    logic [W-1:0] res_flip;
    logic         wide_ovf;

    always_comb begin
        full       = sub ? (a - b) : (a + b);
        narrow_res = {{EXT{full[HW-1]}}, full[HW-1:0]};
        sign_diff  = a ^ b;
        res_flip   = a ^ full;
        // add: same-sign operands; subtract: opposite-sign operands
        wide_ovf   = (sub ? sign_diff[W-1] : ~sign_diff[W-1]) & res_flip[W-1];
        res        = narrow ? narrow_res : full;
        ovf        = narrow ? (narrow_res != full) : wide_ovf;
    end
endmodule

// File: rtl/tiu_mul.sv
module tiu_mul #(
    parameter int W  = 64,
    parameter int HW = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         narrow,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam int PW  = 2 * W;
    localparam int EXT = W - HW;

    logic signed [PW-1:0] prod;
    logic        [W-1:0]  lo;
    logic        [W-1:0]  hi;
    logic        [W-1:0]  narrow_res;

    always_comb begin
        prod       = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
        lo         = prod[W-1:0];
        hi         = prod[PW-1:W];
        narrow_res = {{EXT{lo[HW-1]}}, lo[HW-1:0]};
        res        = narrow ? narrow_res : lo;
        ovf        = narrow ? (narrow_res != lo) : (hi != {W{lo[W-1]}});
    end
endmodule

// File: rtl/trap_int_unit.sv
module trap_int_unit
    import tiu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_vld,
    input  logic            grp_mul,
    input  logic [FN_W-1:0] func,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic            wr_en,
    output logic [XLEN-1:0] wr_data,
    output logic            ovf_trap
);
    localparam int EXT = XLEN - HLEN;

    op_e             dec_op;
    logic            is_long;
    logic [XLEN-1:0] as_res;
    logic            as_ovf;
    logic [XLEN-1:0] mu_res;
    logic            mu_ovf;
    logic            s1_is_mul;
    logic            s1_is_sub;
    logic            s1_narrow;
    pipe_t           pipe_d;
    pipe_t           pipe_q;

    tiu_decode u_dec (
        .vld     (issue_vld),
        .grp_mul (grp_mul),
        .func    (func),
        .op      (dec_op)
    );

    assign is_long   = (dec_op == OP_ADDL) || (dec_op == OP_SUBL) || (dec_op == OP_MULL);
    assign s1_is_mul = (pipe_q.s1.op == OP_MULL) || (pipe_q.s1.op == OP_MULQ);
    assign s1_is_sub = (pipe_q.s1.op == OP_SUBL) || (pipe_q.s1.op == OP_SUBQ);
    assign s1_narrow = (pipe_q.s1.op == OP_ADDL) || (pipe_q.s1.op == OP_SUBL) ||
                       (pipe_q.s1.op == OP_MULL);

    tiu_addsub #(.W(XLEN), .HW(HLEN)) u_as (
        .a      (pipe_q.s1.a),
        .b      (pipe_q.s1.b),
        .sub    (s1_is_sub),
        .narrow (s1_narrow),
        .res    (as_res),
        .ovf    (as_ovf)
    );

    tiu_mul #(.W(XLEN), .HW(HLEN)) u_mul (
        .a      (pipe_q.s1.a),
        .b      (pipe_q.s1.b),
        .narrow (s1_narrow),
        .res    (mu_res),
        .ovf    (mu_ovf)
    );

    always_comb begin
        pipe_d = pipe_q;
        // stage 1: capture decoded op, longword operands sign-extended here
        pipe_d.s1.vld = (dec_op != OP_NONE);
        pipe_d.s1.op  = dec_op;
        pipe_d.s1.a   = is_long ? {{EXT{opnd_a[HLEN-1]}}, opnd_a[HLEN-1:0]} : opnd_a;
        pipe_d.s1.b   = is_long ? {{EXT{opnd_b[HLEN-1]}}, opnd_b[HLEN-1:0]} : opnd_b;
        // stage 2: result and trap retire together
        pipe_d.s2.wen  = pipe_q.s1.vld;
        pipe_d.s2.trap = pipe_q.s1.vld && (s1_is_mul ? mu_ovf : as_ovf);
        if (pipe_q.s1.vld) begin
            pipe_d.s2.data = s1_is_mul ? mu_res : as_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign wr_en    = pipe_q.s2.wen;
    assign wr_data  = pipe_q.s2.data;
    assign ovf_trap = pipe_q.s2.trap;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!wr_en && !ovf_trap));

    p_wen_after_issue_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(issue_vld, 2));

    p_wen_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !$past(issue_vld)) |=> !wr_en);

    p_trap_needs_wen_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_trap |-> wr_en);

    p_long_sext_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(issue_vld && (func == 7'h40 || (!grp_mul && func == 7'h49)), 2))
        |-> (wr_data[XLEN-1:HLEN] == {EXT{wr_data[HLEN-1]}}));

    p_mulq_min_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(issue_vld && grp_mul && func == 7'h60 &&
                        opnd_a == {1'b1, {(XLEN-1){1'b0}}} && opnd_b == {XLEN{1'b1}}, 2))
        |-> (ovf_trap && wr_data == {1'b1, {(XLEN-1){1'b0}}}));

    p_trap_keeps_data_r9: assert property (@(posedge clk) disable iff (rst)
        ovf_trap |-> !$isunknown(wr_data));
endmodule

// File: tb/trap_int_unit_test.sv
`timescale 1ns/1ps
module trap_int_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_vld = 1'b0;
    logic        grp_mul = 1'b0;
    logic [6:0]  func = 7'h0;
    logic [63:0] opnd_a = 64'h0;
    logic [63:0] opnd_b = 64'h0;
    logic        wr_en;
    logic [63:0] wr_data;
    logic        ovf_trap;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [63:0] QMIN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] QMAX = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] NEG1 = 64'hFFFF_FFFF_FFFF_FFFF;

    always #2.5 clk = ~clk;

    trap_int_unit uut (
        .clk      (clk),
        .rst      (rst),
        .issue_vld(issue_vld),
        .grp_mul  (grp_mul),
        .func     (func),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ovf_trap (ovf_trap)
    );

    // reference model from the requirements, using wide signed arithmetic
    function automatic void model(input bit g, input logic [6:0] f,
                                  input logic [63:0] a, input logic [63:0] b,
                                  output bit wen, output logic [63:0] d, output bit tr);
        longint sa, sb, full;
        logic [63:0] s;
        logic signed [127:0] p;
        logic signed [127:0] hi_lim;
        logic signed [127:0] lo_lim;
        sa = longint'($signed(a[31:0]));
        sb = longint'($signed(b[31:0]));
        wen = 1'b1; d = 64'h0; tr = 1'b0;
        hi_lim = 128'sd9223372036854775807;
        lo_lim = -hi_lim - 128'sd1;
        if (!g && (f == 7'h40 || f == 7'h49)) begin
            full = (f == 7'h40) ? sa + sb : sa - sb;
            d  = {{32{full[31]}}, full[31:0]};
            tr = (full > 64'sd2147483647) || (full < -64'sd2147483648);
        end else if (!g && f == 7'h60) begin
            s = a + b; d = s;
            tr = (a[63] == b[63]) && (s[63] != a[63]);
        end else if (!g && f == 7'h69) begin
            s = a - b; d = s;
            tr = (a[63] != b[63]) && (s[63] != a[63]);
        end else if (g && f == 7'h40) begin
            full = sa * sb;
            d  = {{32{full[31]}}, full[31:0]};
            tr = (full > 64'sd2147483647) || (full < -64'sd2147483648);
        end else if (g && f == 7'h60) begin
            p  = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
            d  = p[63:0];
            tr = (p > hi_lim) || (p < lo_lim);
        end else begin
            wen = 1'b0;
        end
    endfunction

    task automatic chk(input string tag, input bit exp_w, input logic [63:0] exp_d, input bit exp_t);
        checks++;
        if (wr_en !== exp_w || ovf_trap !== exp_t || (exp_w && wr_data !== exp_d)) begin
            errors++;
            $display("FAIL %s: got wen=%0b data=%h trap=%0b, expected wen=%0b data=%h trap=%0b",
                     tag, wr_en, wr_data, ovf_trap, exp_w, exp_d, exp_t);
        end
    endtask

    task automatic drive(input bit v, input bit g, input logic [6:0] f,
                         input logic [63:0] a, input logic [63:0] b);
        issue_vld = v; grp_mul = g; func = f; opnd_a = a; opnd_b = b;
    endtask

    // single issue, sample two edges later
    task automatic run_op(input string tag, input bit g, input logic [6:0] f,
                          input logic [63:0] a, input logic [63:0] b);
        bit ew, et;
        logic [63:0] ed;
        model(g, f, a, b, ew, ed, et);
        @(negedge clk); drive(1'b1, g, f, a, b);
        @(negedge clk); drive(1'b0, 1'b0, 7'h0, 64'h0, 64'h0);
        @(negedge clk); chk(tag, ew, ed, et);
    endtask

    task automatic t_reset_r1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset state", 1'b0, 64'h0, 1'b0);
        rst = 1'b0;
        // op in flight is discarded by reset
        @(negedge clk); drive(1'b1, 1'b0, 7'h60, QMAX, 64'h1);
        @(negedge clk); drive(1'b0, 1'b0, 7'h0, 64'h0, 64'h0); rst = 1'b1;
        @(negedge clk); chk("R1 reset kills in-flight op", 1'b0, 64'h0, 1'b0);
        rst = 1'b0;
        @(negedge clk); chk("R1 nothing after reset", 1'b0, 64'h0, 1'b0);
    endtask

    task automatic t_latency_r2;
        @(negedge clk); drive(1'b1, 1'b0, 7'h60, 64'd10, 64'd20);
        @(negedge clk); drive(1'b0, 1'b0, 7'h0, 64'h0, 64'h0);
        chk("R2 not yet after one edge", 1'b0, 64'h0, 1'b0);
        @(negedge clk); chk("R2 retire after two edges", 1'b1, 64'd30, 1'b0);
        @(negedge clk); chk("R2 write is one cycle", 1'b0, 64'h0, 1'b0);
    endtask

    task automatic t_long_addsub_r4;
        run_op("R4 addl overflow up", 1'b0, 7'h40, 64'h0000_0000_7FFF_FFFF, 64'h1);
        run_op("R4 addl upper bits ignored", 1'b0, 7'h40, 64'hDEAD_BEEF_0000_0005, 64'h1234_5678_FFFF_FFFD);
        run_op("R4 subl overflow down", 1'b0, 7'h49, 64'h0000_0000_8000_0000, 64'h1);
        run_op("R4 subl negative result", 1'b0, 7'h49, 64'd5, 64'd7);
    endtask

    task automatic t_addq_r5;
        run_op("R5 addq max+1 traps", 1'b0, 7'h60, QMAX, 64'h1);
        run_op("R5 addq -1+-1 no trap", 1'b0, 7'h60, NEG1, NEG1);
        run_op("R5 addq min+min traps", 1'b0, 7'h60, QMIN, QMIN);
    endtask

    task automatic t_subq_r6;
        run_op("R6 subq min-1 traps", 1'b0, 7'h69, QMIN, 64'h1);
        run_op("R6 subq 0-min traps", 1'b0, 7'h69, 64'h0, QMIN);
        run_op("R6 subq 3-5 no trap", 1'b0, 7'h69, 64'd3, 64'd5);
    endtask

    task automatic t_mull_r7;
        run_op("R7 mull 2^16*2^16 traps", 1'b1, 7'h40, 64'h1_0000, 64'h1_0000);
        run_op("R7 mull -3*4", 1'b1, 7'h40, 64'hFFFF_FFFF_FFFF_FFFD, 64'h0000_0007_0000_0004);
        run_op("R7 mull lmin*-1 traps", 1'b1, 7'h40, 64'h0000_0000_8000_0000, NEG1);
    endtask

    task automatic t_mulq_r8;
        run_op("R8 mulq min*-1 traps", 1'b1, 7'h60, QMIN, NEG1);
        run_op("R8 mulq 2^32*2^31 traps", 1'b1, 7'h60, 64'h1_0000_0000, 64'h8000_0000);
        run_op("R8 mulq -2^32*2^31 fits", 1'b1, 7'h60, 64'hFFFF_FFFF_0000_0000, 64'h8000_0000);
        run_op("R8 mulq large*small", 1'b1, 7'h60, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFF9);
    endtask

    task automatic t_commit_with_trap_r9;
        // trap cycle must carry the wrapped result
        run_op("R9 data written with trap", 1'b0, 7'h60, QMAX, QMAX);
    endtask

    task automatic t_ignored_r10;
        run_op("R10 unknown code 0x41", 1'b0, 7'h41, QMAX, QMAX);
        run_op("R10 0x49 in mul group", 1'b1, 7'h49, QMIN, NEG1);
        @(negedge clk); drive(1'b0, 1'b1, 7'h60, QMIN, NEG1);
        @(negedge clk); drive(1'b0, 1'b0, 7'h0, 64'h0, 64'h0);
        @(negedge clk); chk("R10 valid low ignored", 1'b0, 64'h0, 1'b0);
    endtask

    task automatic t_stream_r11;
        bit          g  [6];
        logic [6:0]  f  [6];
        logic [63:0] a  [6];
        logic [63:0] b  [6];
        bit          ew [6];
        logic [63:0] ed [6];
        bit          et [6];
        g[0]=0; f[0]=7'h60; a[0]=QMAX;  b[0]=64'h1;
        g[1]=1; f[1]=7'h60; a[1]=64'd7; b[1]=64'd6;
        g[2]=0; f[2]=7'h49; a[2]=64'h8000_0000; b[2]=64'h1;
        g[3]=1; f[3]=7'h40; a[3]=64'd100; b[3]=64'hFFFF_FFFF_FFFF_FFFE;
        g[4]=0; f[4]=7'h41; a[4]=QMAX;  b[4]=QMAX;
        g[5]=0; f[5]=7'h69; a[5]=QMIN;  b[5]=QMAX;
        for (int i = 0; i < 6; i++) model(g[i], f[i], a[i], b[i], ew[i], ed[i], et[i]);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (c >= 2) chk($sformatf("R11 stream slot %0d", c - 2), ew[c-2], ed[c-2], et[c-2]);
            if (c < 6) drive(1'b1, g[c], f[c], a[c], b[c]);
            else       drive(1'b0, 1'b0, 7'h0, 64'h0, 64'h0);
        end
    endtask

    initial begin
        t_reset_r1;
        t_latency_r2;
        t_long_addsub_r4;
        t_addq_r5;
        t_subq_r6;
        t_mull_r7;
        t_mulq_r8;
        t_commit_with_trap_r9;
        t_ignored_r10;
        t_stream_r11;
        // R3: trap never outside a write is covered by every check above
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule